// File: doc/BRIEF.md
# Output Virtual-Channel Allocator with Credit Tracking

This block sits on one output port of a network router. It keeps, for every virtual channel of the downstream input buffer, a busy flag and a credit counter. Input ports whose head flit has been routed to this output raise a request; in the same cycle the block picks one requester and hands it the lowest-numbered output VC that is not held by another packet. The grant is combinational, so allocation fits in the single router cycle alongside routing, switch allocation and crossbar traversal.

Flits leaving on the output link are reported through a send strobe carrying the VC number and a tail marker. Each accepted send consumes one credit; credit tokens coming back from the downstream router on their own dedicated link restore one credit each. Sending the tail flit of a packet releases its VC. A run-time input chooses between a rotating (round-robin) priority among requesters and a fixed priority that always favours the lowest-numbered input port.

Top module: `vc_out_alloc`

## Requirements
- R1: After reset every output VC is free, every credit counter equals the downstream buffer depth (4 by default), every VC reports ready, and the rotating priority starts at input port 0.
- R2: When at least one request is raised and at least one VC is free, exactly one requesting port is granted and `grant_vc` names the lowest-numbered free VC; with no request or no free VC, no grant is given.
- R3: The VC named in a grant reads busy from the next cycle on.
- R4: With `prio_fixed` = 1, the lowest-numbered requesting port wins.
- R5: With `prio_fixed` = 0, the search starts at the port just after the most recently granted one (granting in either mode moves this point) and wraps around; a cycle with no grant leaves it unchanged.
- R6: An accepted send lowers the credit counter of its VC by one; `vc_ready` bit i is 1 exactly when counter i is nonzero.
- R7: A returned credit token raises its VC's counter by one; a send and a return on the same VC in one cycle leave the counter unchanged.
- R8: An accepted send with `tx_tail` = 1 frees its VC in the next cycle.
- R9: A send on a VC whose counter is zero is ignored: counter and busy flag are unchanged.
- R10: A credit return on a VC whose counter already equals the buffer depth (and no accepted send that cycle) is ignored; the counter never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_fixed | input | 1 | 1 = fixed priority, 0 = round-robin |
| head_req | input | NUM_IN | Bit p: port p has a head flit routed here |
| grant | output | NUM_IN | One-hot grant to the winning port |
| grant_vc | output | VCW | Output VC given with the grant |
| vc_busy | output | NUM_VC | Bit v: output VC v held by a packet |
| vc_ready | output | NUM_VC | Bit v: output VC v has at least one credit |
| tx_valid | input | 1 | A flit is being sent on the link |
| tx_vc | input | VCW | VC of the sent flit |
| tx_tail | input | 1 | Sent flit is the tail of its packet |
| crd_valid | input | 1 | A credit token arrives on the credit link |
| crd_vc | input | VCW | VC the credit token belongs to |
| credits | output | NUM_VC*CW | Counter of VC v in bits [v*CW +: CW] |

## Verification
The assertions take for granted that `tx_vc` and `crd_vc` name existing VCs and that the upstream side sends flits only on VCs it holds. The stimulus drives the VC fields only with values below the VC count, releases every granted VC with a tail send before reusing it, and issues sends beyond the credit limit and returns beyond the depth on purpose, so that the ignore rules of R9 and R10 are exercised at the ports rather than by violating those premises.

// File: rtl/vca_pkg.sv
package vca_pkg;
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic int cnt_w(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/vca_arbiter.sv
module vca_arbiter
   import vca_pkg::*;
#(
   parameter int NUM_IN = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fixed_mode,
   input  logic              enable,
   input  logic [NUM_IN-1:0] req,
   output logic [NUM_IN-1:0] gnt,
   output logic              gnt_any
);
   localparam int IW = idx_w(NUM_IN);

   generate
      if (NUM_IN < 2) begin : g_bad_in
         $error("vca_arbiter needs at least two requesters");
      end
   endgenerate

   logic [IW-1:0] start_q;
   logic [IW-1:0] win_idx;

   always_comb begin
      gnt     = '0;
      gnt_any = 1'b0;
      win_idx = '0;
      if (enable) begin
         for (int k = 0; k < NUM_IN; k++) begin
            automatic int j = fixed_mode ? k : int'(start_q) + k;
            if (j >= NUM_IN) j = j - NUM_IN;
            if (!gnt_any && req[j]) begin
               gnt_any  = 1'b1;
               gnt[j]   = 1'b1;
               win_idx  = IW'(j);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (gnt_any) begin
         start_q <= (int'(win_idx) == NUM_IN - 1) ? '0 : win_idx + IW'(1);
      end
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)) else $error("grant not one-hot"); // R2
   AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0) else $error("grant without request"); // R2
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_any |=> $stable(start_q)) else $error("pointer moved idle"); // R5
endmodule

// File: rtl/vca_vc_slot.sv
module vca_vc_slot
   import vca_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic                    send,
   input  logic                    send_tail,
   input  logic                    ret,
   output logic                    busy,
   output logic                    ready,
   output logic [cnt_w(DEPTH)-1:0] count
);
   localparam int CW = cnt_w(DEPTH);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("vca_vc_slot needs a buffer depth of at least one");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          fire;

   assign fire  = send && (cnt_q != '0);
   assign ready = (cnt_q != '0);
   assign busy  = busy_q;
   assign count = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= FULL;
      end else if (fire && !ret) begin
         cnt_q <= cnt_q - CW'(1);
      end else if (ret && !fire && cnt_q != FULL) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (take) begin
         busy_q <= 1'b1;
      end else if (fire && send_tail) begin
         busy_q <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL) else $error("credit above depth"); // R10
   AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy_q) else $error("granted VC not busy"); // R3
   AST_TAIL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (send && send_tail && ready && !take) |=> !busy_q) else $error("tail did not free VC"); // R8
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !ret) |=> (cnt_q == '0)) else $error("send on empty VC changed count"); // R9
endmodule

// File: rtl/vc_out_alloc.sv
module vc_out_alloc
   import vca_pkg::*;
#(
   parameter int NUM_IN = 5,
   parameter int NUM_VC = 2,
   parameter int DEPTH  = 4,
   localparam int VCW   = idx_w(NUM_VC),
   localparam int CW    = cnt_w(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prio_fixed,
   input  logic [NUM_IN-1:0]    head_req,
   output logic [NUM_IN-1:0]    grant,
   output logic [VCW-1:0]       grant_vc,
   output logic [NUM_VC-1:0]    vc_busy,
   output logic [NUM_VC-1:0]    vc_ready,
   input  logic                 tx_valid,
   input  logic [VCW-1:0]       tx_vc,
   input  logic                 tx_tail,
   input  logic                 crd_valid,
   input  logic [VCW-1:0]       crd_vc,
   output logic [NUM_VC*CW-1:0] credits
);
   generate
      if (NUM_VC < 1) begin : g_bad_vc
         $error("vc_out_alloc needs at least one output VC");
      end
   endgenerate

   logic              any_free;
   logic [VCW-1:0]    free_idx;
   logic              gnt_any;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int v = 0; v < NUM_VC; v++) begin
         if (!any_free && !vc_busy[v]) begin
            any_free = 1'b1;
            free_idx = VCW'(v);
         end
      end
   end

   assign grant_vc = free_idx;

   vca_arbiter #(.NUM_IN(NUM_IN)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .fixed_mode (prio_fixed),
      .enable     (any_free),
      .req        (head_req),
      .gnt        (grant),
      .gnt_any    (gnt_any)
   );

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic [CW-1:0] cnt;
      vca_vc_slot #(.DEPTH(DEPTH)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .take      (gnt_any && (free_idx == VCW'(v))),
         .send      (tx_valid && (tx_vc == VCW'(v))),
         .send_tail (tx_tail),
         .ret       (crd_valid && (crd_vc == VCW'(v))),
         .busy      (vc_busy[v]),
         .ready     (vc_ready[v]),
         .count     (cnt)
      );
      assign credits[v*CW +: CW] = cnt;
   end

   AST_GNT_FREE_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> !vc_busy[grant_vc]) else $error("grant of busy VC"); // R2
   AST_NO_FREE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (&vc_busy) |-> (grant == '0)) else $error("grant with all VCs busy"); // R2
endmodule

// File: tb/vc_out_alloc_test.sv
module vc_out_alloc_test;
   localparam int NI = 5;
   localparam int NV = 2;
   localparam int DP = 4;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prio_fixed = 1'b0;
   logic [NI-1:0] head_req = '0;
   logic [NI-1:0] grant;
   logic [0:0]    grant_vc;
   logic [NV-1:0] vc_busy, vc_ready;
   logic          tx_valid = 1'b0, tx_tail = 1'b0, crd_valid = 1'b0;
   logic [0:0]    tx_vc = '0, crd_vc = '0;
   logic [NV*CW-1:0] credits;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   vc_out_alloc #(.NUM_IN(NI), .NUM_VC(NV), .DEPTH(DP)) uut (
      .clk(clk), .rst_n(rst_n), .prio_fixed(prio_fixed), .head_req(head_req),
      .grant(grant), .grant_vc(grant_vc), .vc_busy(vc_busy), .vc_ready(vc_ready),
      .tx_valid(tx_valid), .tx_vc(tx_vc), .tx_tail(tx_tail),
      .crd_valid(crd_valid), .crd_vc(crd_vc), .credits(credits));

   // Entry: {fixed, request[4:0], expected grant[4:0]}, run in order (round-robin state carries over)
   localparam logic [10:0] VEC [10] = '{
      {1'b1, 5'b10110, 5'b00010},
      {1'b0, 5'b10110, 5'b00100},
      {1'b0, 5'b10110, 5'b10000},
      {1'b0, 5'b10110, 5'b00010},
      {1'b0, 5'b00001, 5'b00001},
      {1'b1, 5'b11000, 5'b01000},
      {1'b0, 5'b11001, 5'b10000},
      {1'b0, 5'b11001, 5'b00001},
      {1'b0, 5'b00000, 5'b00000},
      {1'b0, 5'b01001, 5'b01000}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int cred(input int v);
      return int'(credits[v*CW +: CW]);
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input int v, input bit tail, input bit ret);
      tx_valid = 1'b1; tx_vc = 1'(v); tx_tail = tail;
      crd_valid = ret; crd_vc = 1'(v);
      tick();
      tx_valid = 1'b0; tx_tail = 1'b0; crd_valid = 1'b0;
   endtask

   task automatic give_back(input int v);
      crd_valid = 1'b1; crd_vc = 1'(v);
      tick();
      crd_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", int'(vc_busy), 0);
      check("R1 ready", int'(vc_ready), 3);
      check("R1 credit vc0", cred(0), DP);
      check("R1 credit vc1", cred(1), DP);

      // Table walk: R4 fixed priority, R5 rotation, R3/R7/R8 per granted vector
      for (int i = 0; i < 10; i++) begin
         prio_fixed = VEC[i][10];
         head_req   = VEC[i][9:5];
         #1;
         check(VEC[i][10] ? "R4 grant" : "R5 grant", int'(grant), int'(VEC[i][4:0]));
         if (VEC[i][4:0] != '0) check("R2 grant_vc", int'(grant_vc), 0);
         tick();
         head_req = '0;
         if (VEC[i][4:0] != '0) begin
            check("R3 busy", int'(vc_busy), 1);
            send(0, 1'b1, 1'b1);
            check("R8 freed", int'(vc_busy), 0);
            check("R7 send+return", cred(0), DP);
         end
      end

      // R2 lowest free VC, then second VC, then none free
      prio_fixed = 1'b1;
      head_req = 5'b00011;
      #1;
      check("R2 first grant", int'(grant), 1);
      check("R2 first vc", int'(grant_vc), 0);
      tick();
      head_req = 5'b00010;
      #1;
      check("R2 second grant", int'(grant), 2);
      check("R2 second vc", int'(grant_vc), 1);
      tick();
      head_req = 5'b00100;
      #1;
      check("R2 no free VC", int'(grant), 0);
      check("R3 both busy", int'(vc_busy), 3);
      tick();
      head_req = '0;

      // R6 drain credits of VC1
      for (int k = 1; k <= DP; k++) begin
         send(1, 1'b0, 1'b0);
         check("R6 decrement", cred(1), DP - k);
      end
      check("R6 ready drop", int'(vc_ready), 1);
      // R9 send on empty VC ignored, tail included
      send(1, 1'b1, 1'b0);
      check("R9 count held", cred(1), 0);
      check("R9 busy held", int'(vc_busy[1]), 1);
      // R7 return
      give_back(1);
      check("R7 increment", cred(1), 1);
      check("R6 ready back", int'(vc_ready[1]), 1);
      send(1, 1'b1, 1'b0);
      check("R8 tail frees", int'(vc_busy[1]), 0);
      check("R6 last credit", cred(1), 0);
      for (int k = 0; k < DP; k++) give_back(1);
      check("R7 refill", cred(1), DP);
      // R10 return beyond depth ignored
      give_back(1);
      check("R10 saturate", cred(1), DP);
      send(0, 1'b1, 1'b0);
      check("R8 vc0 freed", int'(vc_busy), 0);
      give_back(0);
      check("R10 vc0 restored", cred(0), DP);

      // R5 idle cycle keeps rotation: last grant port1, so start at port2
      prio_fixed = 1'b0;
      tick();
      head_req = 5'b00111;
      #1;
      check("R5 after idle", int'(grant), 4);
      tick();
      head_req = '0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule